// File: doc/BRIEF.md
# Hypervisor Interrupt Source Register Bank

This block holds the hypervisor-level interrupt sources of one processor strand and turns them into request lines for the trap logic. It stores four head/tail pointer pairs, one pair for each of four work queues: processor cross-calls, device cross-calls, resumable errors and non-resumable errors. It also stores a pending-interrupt word, a hypervisor state word and a hypervisor trap base address. The queue memory itself, the packet contents and trap dispatch live elsewhere.

Software reaches the registers through one address, a write strobe and write data, and reads through a combinational read port on the same address. Each request is computed from the current register contents and the current trap level. A queue requests service while its head differs from its tail. The pending word requests service while it is nonzero. A trap-level-zero request is raised when the state word asks for one, the strand is at trap level 0, and hypervisor privilege is off.

Top module: `hv_irq_status`

## Requirements
- R1: While `rst` is high at a clock edge, every pointer, the pending word and the trap base are cleared, and the state word is loaded with 0x804 (id bit 11 and privilege bit 2 set). After reset all five request outputs are low.
- R2: `irq_cpu_mondo` is high exactly when the processor cross-call head (address 0) differs from its tail (address 1).
- R3: `irq_dev_mondo` follows the same rule for the device pair (head 2, tail 3), and `irq_res_err` follows it for the resumable error pair (head 4, tail 5).
- R4: The non-resumable error pointers (head 6, tail 7) are stored as written and read back, and no value of them changes any request output.
- R5: The pending word (address 8) keeps the low `PEND_W` bits of the written data, with upper bits zero. `irq_hv_pend` is high whenever the stored word is nonzero.
- R6: A write to the state word (address 9) stores the data with bit 11 forced to 1. All other bits are kept as written.
- R7: `irq_tl_zero` is high exactly when state bit 0 is 1, state bit 2 is 0 and `trap_level` is 0. It follows `trap_level` in the same cycle.
- R8: A write to the trap base (address 10) stores the data with the low `TBA_LOW` (15) bits cleared, and those bits always read as zero.
- R9: `rd_data` shows the register at `addr` in the same cycle. Addresses 11 to 15 read as zero, and writes to them change no register and no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 4 | Register address for read and write |
| wr_en | input | 1 | Write strobe, captured at the rising edge |
| wr_data | input | DATA_W | Write data |
| rd_data | output | DATA_W | Combinational read data of the register at `addr` |
| trap_level | input | TL_W | Current trap level of the strand |
| irq_cpu_mondo | output | 1 | Processor cross-call queue not empty |
| irq_dev_mondo | output | 1 | Device cross-call queue not empty |
| irq_res_err | output | 1 | Resumable error queue not empty |
| irq_hv_pend | output | 1 | Pending word nonzero |
| irq_tl_zero | output | 1 | Trap-level-zero request |

## Verification
A write takes effect at the rising edge that captures it. Its read-back value and any request it changes appear in the cycle after that edge, with no extra register stage. Read data and the trap-level-zero request respond to `addr` and `trap_level` in the same cycle, with no clock. For this reason the bench drives new inputs just after a falling edge and lets them settle for one nanosecond. It then compares every output against a behavioural model whose registers change only when the bench sees the rising edge, so each check lands in the cycle its result is due.

// File: rtl/hv_irq_pkg.sv
package hv_irq_pkg;

    localparam int ADDR_W     = 4;
    localparam int NUM_QUEUES = 4;

    // register addresses; queue pairs sit at 2q (head) and 2q+1 (tail)
    typedef enum logic [ADDR_W-1:0] {
        RA_CPU_HEAD  = 4'd0,
        RA_CPU_TAIL  = 4'd1,
        RA_DEV_HEAD  = 4'd2,
        RA_DEV_TAIL  = 4'd3,
        RA_RES_HEAD  = 4'd4,
        RA_RES_TAIL  = 4'd5,
        RA_NRES_HEAD = 4'd6,
        RA_NRES_TAIL = 4'd7,
        RA_PEND      = 4'd8,
        RA_STATE     = 4'd9,
        RA_TBA       = 4'd10
    } hv_reg_e;

    localparam logic [ADDR_W-1:0] REG_COUNT = 4'd11;

    // which queues may raise a request (bit q for queue q)
    localparam logic [NUM_QUEUES-1:0] QUEUE_RAISES = 4'b0111;

    // state word bit positions
    localparam int ST_TLZ   = 0;
    localparam int ST_HPRIV = 2;
    localparam int ST_ID    = 11;

    typedef struct packed {
        logic cpu_mondo;
        logic dev_mondo;
        logic res_err;
        logic hv_pend;
        logic tl_zero;
    } hv_irq_t;

    function automatic logic [ADDR_W-1:0] head_addr(input int q);
        return ADDR_W'(2 * q);
    endfunction

    function automatic logic [ADDR_W-1:0] tail_addr(input int q);
        return ADDR_W'(2 * q + 1);
    endfunction

endpackage

// File: rtl/hv_queue_ptrs.sv
module hv_queue_ptrs #(
    parameter int DATA_W = 64,
    parameter bit RAISES = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_head,
    input  logic              wr_tail,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] head_q,
    output logic [DATA_W-1:0] tail_q,
    output logic              irq
);

    always_ff @(posedge clk) begin
        if (rst) begin
            head_q <= '0;
            tail_q <= '0;
        end else begin
            if (wr_head) head_q <= wr_data;
            if (wr_tail) tail_q <= wr_data;
        end
    end

    generate
        if (RAISES) begin : g_raise
            assign irq = (head_q != tail_q);
        end else begin : g_quiet
            assign irq = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/hv_pend_reg.sv
module hv_pend_reg #(
    parameter int DATA_W = 64,
    parameter int PEND_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] pend_q,
    output logic              irq
);

    localparam logic [DATA_W-1:0] PEND_MASK =
        {{(DATA_W-PEND_W){1'b0}}, {PEND_W{1'b1}}};

    always_ff @(posedge clk) begin
        if (rst)     pend_q <= '0;
        else if (wr) pend_q <= wr_data & PEND_MASK;
    end

    assign irq = |pend_q;

endmodule

// File: rtl/hv_state_reg.sv
module hv_state_reg #(
    parameter int DATA_W = 64,
    parameter int TL_W   = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [TL_W-1:0]   trap_level,
    output logic [DATA_W-1:0] state_q,
    output logic              irq_tlz
);
    import hv_irq_pkg::*;

    localparam logic [DATA_W-1:0] ID_MASK    = DATA_W'(1) << ST_ID;
    localparam logic [DATA_W-1:0] HPRIV_MASK = DATA_W'(1) << ST_HPRIV;
    localparam logic [DATA_W-1:0] STATE_RST  = ID_MASK | HPRIV_MASK;

    always_ff @(posedge clk) begin
        if (rst)     state_q <= STATE_RST;
        else if (wr) state_q <= wr_data | ID_MASK;
    end

    assign irq_tlz = state_q[ST_TLZ] && !state_q[ST_HPRIV] && (trap_level == '0);

endmodule

// File: rtl/hv_tba_reg.sv
module hv_tba_reg #(
    parameter int DATA_W  = 64,
    parameter int TBA_LOW = 15
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] tba_q
);

    localparam logic [DATA_W-1:0] TBA_MASK =
        {{(DATA_W-TBA_LOW){1'b1}}, {TBA_LOW{1'b0}}};

    always_ff @(posedge clk) begin
        if (rst)     tba_q <= '0;
        else if (wr) tba_q <= wr_data & TBA_MASK;
    end

endmodule

// File: rtl/hv_irq_status.sv
module hv_irq_status #(
    parameter int DATA_W  = 64,
    parameter int TL_W    = 3,
    parameter int PEND_W  = 16,
    parameter int TBA_LOW = 15
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic [hv_irq_pkg::ADDR_W-1:0]  addr,
    input  logic                           wr_en,
    input  logic [DATA_W-1:0]              wr_data,
    output logic [DATA_W-1:0]              rd_data,
    input  logic [TL_W-1:0]                trap_level,
    output logic                           irq_cpu_mondo,
    output logic                           irq_dev_mondo,
    output logic                           irq_res_err,
    output logic                           irq_hv_pend,
    output logic                           irq_tl_zero
);
    import hv_irq_pkg::*;

    logic [DATA_W-1:0]     head_q [NUM_QUEUES];
    logic [DATA_W-1:0]     tail_q [NUM_QUEUES];
    logic [NUM_QUEUES-1:0] q_irq;
    logic [DATA_W-1:0]     pend_q;
    logic [DATA_W-1:0]     state_q;
    logic [DATA_W-1:0]     tba_q;
    hv_irq_t               irqs;

    generate
        for (genvar q = 0; q < NUM_QUEUES; q++) begin : g_queue
            localparam logic [ADDR_W-1:0] HA = head_addr(q);
            localparam logic [ADDR_W-1:0] TA = tail_addr(q);
            hv_queue_ptrs #(
                .DATA_W (DATA_W),
                .RAISES (QUEUE_RAISES[q])
            ) u_q (
                .clk     (clk),
                .rst     (rst),
                .wr_head (wr_en && addr == HA),
                .wr_tail (wr_en && addr == TA),
                .wr_data (wr_data),
                .head_q  (head_q[q]),
                .tail_q  (tail_q[q]),
                .irq     (q_irq[q])
            );
        end
    endgenerate

    hv_pend_reg #(.DATA_W(DATA_W), .PEND_W(PEND_W)) u_pend (
        .clk     (clk),
        .rst     (rst),
        .wr      (wr_en && addr == RA_PEND),
        .wr_data (wr_data),
        .pend_q  (pend_q),
        .irq     (irqs.hv_pend)
    );

    hv_state_reg #(.DATA_W(DATA_W), .TL_W(TL_W)) u_state (
        .clk        (clk),
        .rst        (rst),
        .wr         (wr_en && addr == RA_STATE),
        .wr_data    (wr_data),
        .trap_level (trap_level),
        .state_q    (state_q),
        .irq_tlz    (irqs.tl_zero)
    );

    hv_tba_reg #(.DATA_W(DATA_W), .TBA_LOW(TBA_LOW)) u_tba (
        .clk     (clk),
        .rst     (rst),
        .wr      (wr_en && addr == RA_TBA),
        .wr_data (wr_data),
        .tba_q   (tba_q)
    );

    assign irqs.cpu_mondo = q_irq[0];
    assign irqs.dev_mondo = q_irq[1];
    assign irqs.res_err   = q_irq[2];

    assign irq_cpu_mondo = irqs.cpu_mondo;
    assign irq_dev_mondo = irqs.dev_mondo;
    assign irq_res_err   = irqs.res_err;
    assign irq_hv_pend   = irqs.hv_pend;
    assign irq_tl_zero   = irqs.tl_zero;

    always_comb begin
        rd_data = '0;
        if (addr < REG_COUNT) begin
            case (addr)
                RA_PEND:  rd_data = pend_q;
                RA_STATE: rd_data = state_q;
                RA_TBA:   rd_data = tba_q;
                default:  rd_data = addr[0] ? tail_q[addr[ADDR_W-1:1]]
                                            : head_q[addr[ADDR_W-1:1]];
            endcase
        end
    end

endmodule

// File: rtl/hv_irq_status_chk.sv
module hv_irq_status_chk #(
    parameter int DATA_W  = 64,
    parameter int TL_W    = 3,
    parameter int PEND_W  = 16,
    parameter int TBA_LOW = 15
) (
    input logic              clk,
    input logic              rst,
    input logic [3:0]        addr,
    input logic              wr_en,
    input logic [DATA_W-1:0] wr_data,
    input logic [DATA_W-1:0] rd_data,
    input logic [TL_W-1:0]   trap_level,
    input logic              irq_cpu_mondo,
    input logic              irq_hv_pend,
    input logic              irq_tl_zero,
    input logic [DATA_W-1:0] cpu_head,
    input logic [DATA_W-1:0] state_q,
    input logic              nres_irq
);
    import hv_irq_pkg::*;

    localparam logic [DATA_W-1:0] PEND_MASK =
        {{(DATA_W-PEND_W){1'b0}}, {PEND_W{1'b1}}};
    localparam logic [DATA_W-1:0] STATE_RST =
        (DATA_W'(1) << ST_ID) | (DATA_W'(1) << ST_HPRIV);

    a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (state_q == STATE_RST) && !irq_cpu_mondo && !irq_hv_pend);

    a_r2_equal_clears: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == RA_CPU_TAIL && wr_data == cpu_head) |=> !irq_cpu_mondo);

    a_r4_nres_silent: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (addr == RA_NRES_HEAD || addr == RA_NRES_TAIL)) |=> !nres_irq);

    a_r5_pend_raises: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == RA_PEND && (wr_data & PEND_MASK) != '0) |=> irq_hv_pend);

    a_r6_id_forced: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == RA_STATE) |=> state_q[ST_ID]);

    a_r7_tlz_gated: assert property (@(posedge clk) disable iff (rst)
        irq_tl_zero |-> (trap_level == '0) && !state_q[ST_HPRIV] && state_q[ST_TLZ]);

    a_r8_tba_low_zero: assert property (@(posedge clk) disable iff (rst)
        (addr == RA_TBA) |-> (rd_data[TBA_LOW-1:0] == '0));

    a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
        (addr >= REG_COUNT) |-> (rd_data == '0));

endmodule

bind hv_irq_status hv_irq_status_chk #(
    .DATA_W (DATA_W),
    .TL_W   (TL_W),
    .PEND_W (PEND_W),
    .TBA_LOW(TBA_LOW)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .addr          (addr),
    .wr_en         (wr_en),
    .wr_data       (wr_data),
    .rd_data       (rd_data),
    .trap_level    (trap_level),
    .irq_cpu_mondo (irq_cpu_mondo),
    .irq_hv_pend   (irq_hv_pend),
    .irq_tl_zero   (irq_tl_zero),
    .cpu_head      (head_q[0]),
    .state_q       (state_q),
    .nres_irq      (q_irq[3])
);

// File: tb/hv_irq_status_test.sv
module hv_irq_status_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic [63:0] wr_data = '0;
    logic [63:0] rd_data;
    logic [2:0]  trap_level = '0;
    logic        irq_cpu_mondo, irq_dev_mondo, irq_res_err, irq_hv_pend, irq_tl_zero;

    int checks = 0;
    int errors = 0;

    // behavioural model: one 64-bit word per address
    logic [63:0] m [16];

    hv_irq_status uut (
        .clk           (clk),
        .rst           (rst),
        .addr          (addr),
        .wr_en         (wr_en),
        .wr_data       (wr_data),
        .rd_data       (rd_data),
        .trap_level    (trap_level),
        .irq_cpu_mondo (irq_cpu_mondo),
        .irq_dev_mondo (irq_dev_mondo),
        .irq_res_err   (irq_res_err),
        .irq_hv_pend   (irq_hv_pend),
        .irq_tl_zero   (irq_tl_zero)
    );

    always #2 clk = ~clk;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 16; i++) m[i] = '0;
        m[9] = 64'h804;
    endtask

    task automatic model_write(input logic [3:0] a, input logic [63:0] d);
        if (a <= 4'd7)       m[a] = d;
        else if (a == 4'd8)  m[a] = d & 64'hFFFF;
        else if (a == 4'd9)  m[a] = d | 64'h800;
        else if (a == 4'd10) m[a] = d & ~64'h7FFF;
    endtask

    function automatic string rd_tag(input logic [3:0] a);
        if (a <= 4'd1)  return "R2 read";
        if (a <= 4'd5)  return "R3 read";
        if (a <= 4'd7)  return "R4 read";
        if (a == 4'd8)  return "R5 read";
        if (a == 4'd9)  return "R6 read";
        if (a == 4'd10) return "R8 read";
        return "R9 read";
    endfunction

    task automatic compare_all();
        chk(rd_tag(addr), rd_data, m[addr]);
        chk("R2 irq_cpu_mondo", 64'(irq_cpu_mondo), 64'(m[0] != m[1]));
        chk("R3 irq_dev_mondo", 64'(irq_dev_mondo), 64'(m[2] != m[3]));
        chk("R3 irq_res_err",   64'(irq_res_err),   64'(m[4] != m[5]));
        chk("R5 irq_hv_pend",   64'(irq_hv_pend),   64'(m[8] != 0));
        chk("R7 irq_tl_zero",   64'(irq_tl_zero),
            64'(m[9][0] && !m[9][2] && trap_level == 3'd0));
    endtask

    // drive after a falling edge, settle, compare, then let the rising edge act
    task automatic step(input logic [3:0] a, input logic we, input logic [63:0] d,
                        input logic [2:0] tl);
        addr = a; wr_en = we; wr_data = d; trap_level = tl;
        #1;
        compare_all();
        @(posedge clk);
        if (we) model_write(a, d);
        @(negedge clk);
    endtask

    initial begin
        #(4 * 50000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        addr = 4'd9; #1;
        chk("R1 state after reset", rd_data, 64'h804);
        chk("R1 requests after reset",
            64'({irq_cpu_mondo, irq_dev_mondo, irq_res_err, irq_hv_pend, irq_tl_zero}), 64'd0);
        addr = 4'd0; #1;
        chk("R1 pointer after reset", rd_data, 64'd0);
        @(negedge clk);

        // R2: cpu pair raises then clears
        step(4'd0, 1'b1, 64'd5, 3'd0);
        step(4'd0, 1'b0, 64'd0, 3'd0);
        step(4'd1, 1'b1, 64'd5, 3'd0);
        step(4'd1, 1'b0, 64'd0, 3'd0);
        // R3: device and resumable pairs
        step(4'd3, 1'b1, 64'd3, 3'd0);
        step(4'd4, 1'b1, 64'd9, 3'd0);
        step(4'd2, 1'b1, 64'd3, 3'd0);
        step(4'd5, 1'b1, 64'd9, 3'd0);
        // R4: non-resumable pointers store but never request
        step(4'd6, 1'b1, 64'd7, 3'd0);
        step(4'd6, 1'b0, 64'd0, 3'd0);
        chk("R4 no request from nres",
            64'({irq_cpu_mondo, irq_dev_mondo, irq_res_err}), 64'd0);
        step(4'd7, 1'b1, 64'hDEAD_BEEF_0000_0001, 3'd0);
        // R5: pending word masked and nonzero test
        step(4'd8, 1'b1, 64'hFFFF_0000_0000_0010, 3'd0);
        step(4'd8, 1'b1, 64'hFFFF_0000_0000_0000, 3'd0);
        step(4'd8, 1'b0, 64'd0, 3'd0);
        // R6/R7: state word and trap-level-zero gating
        step(4'd9, 1'b1, 64'h1, 3'd0);
        step(4'd9, 1'b0, 64'd0, 3'd0);
        step(4'd9, 1'b0, 64'd0, 3'd2);
        step(4'd9, 1'b1, 64'h5, 3'd0);
        step(4'd9, 1'b1, 64'hF000_0000_0000_0001, 3'd1);
        step(4'd9, 1'b0, 64'd0, 3'd0);
        // R8: trap base low bits
        step(4'd10, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 3'd0);
        step(4'd10, 1'b0, 64'd0, 3'd0);
        // R9: unmapped addresses
        step(4'd13, 1'b1, 64'h1234, 3'd0);
        step(4'd15, 1'b0, 64'd0, 3'd0);
        step(4'd0,  1'b0, 64'd0, 3'd0);

        // mixed traffic with small values so pointer equality is frequent
        for (int i = 0; i < 400; i++) begin
            logic [3:0]  a;
            logic [63:0] d;
            a = 4'($urandom % 16);
            d = (($urandom % 4) == 0) ? {$urandom, $urandom} : 64'($urandom % 4);
            step(a, 1'($urandom % 2), d, 3'($urandom % 3));
        end

        // R1: reset again in the middle of traffic
        rst = 1'b1;
        @(posedge clk);
        model_reset();
        @(negedge clk);
        rst = 1'b0;
        step(4'd9, 1'b0, 64'd0, 3'd0);
        chk("R1 requests after second reset",
            64'({irq_cpu_mondo, irq_dev_mondo, irq_res_err, irq_hv_pend, irq_tl_zero}), 64'd0);

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule